// File: doc/BRIEF.md
# Cascaded Two-Stage Interrupt Controller

This block joins two 8-input interrupt controllers in a primary/secondary cascade, giving 16 request lines. Lines 0-7 enter the primary unit. Lines 8-15 enter the secondary unit, whose combined request takes the place of primary line 2. Each unit is set up through its own command port and data port on a byte-wide write bus. After setup, each unit resolves its pending requests by fixed priority and tracks which levels are being serviced.

The processor sees a single request output, `intReq`. It answers with a one-cycle `intAck` pulse, and in the next cycle `ackVector` holds the vector of the source it was granted. Once the handler finishes, software writes a specific end-of-interrupt command to the unit or units involved. A secondary source needs such a command on both units before a lower or equal level can be served again.

Top module: `picPair`

## Requirements
- R1: After reset, `intReq` is 0 and `ackVector` is 0x00. The primary mask is 0xFB and the secondary mask is 0xFF. The vector bases are 0x00 (primary) and 0x08 (secondary). A unit that has not been initialized accepts mask writes.
- R2: Bus encoding: `regSel[1]` = 0 selects the primary unit and 1 selects the secondary. `regSel[0]` = 0 selects the command port and 1 the data port. A command byte with bit 4 set starts initialization of that unit and clears its pending and in-service bits. The next three data writes are taken in order as vector base, cascade word and mode word, and the mask is left unchanged. Until the third of those writes, the unit forwards no request.
- R3: The vector returned is bits 7:3 of the unit's base with the 3-bit level in bits 2:0. The low three bits written to the base are ignored.
- R4: Once initialized, a data write loads that unit's mask, and a 1 bit blocks its line. A request that arrives on a masked line stays pending and is forwarded once the line is unmasked.
- R5: A rising edge on a request input makes that line pending. A line held high does not request again after it is acknowledged; it must fall and rise first.
- R6: Input `irqIn[2]` is not a request source, because primary line 2 carries the secondary unit's request.
- R7: In each unit, the lowest-numbered eligible line wins. The secondary unit competes at primary level 2.
- R8: A unit forwards its winning request only when that request outranks every level it has in service.
- R9: On `intAck` with a request forwarded, the winning line leaves the pending set and enters the in-service set. If the secondary unit wins, the primary unit also marks level 2 in service, and the secondary unit supplies the vector.
- R10: A command byte whose bits 7:5 are 011 clears only the in-service bit of the level in bits 2:0. Any other command byte with bit 4 clear has no effect.
- R11: A secondary interrupt is only fully retired after a specific end-of-interrupt to the secondary unit for (line − 8) and one to the primary unit for level 2. Either command alone keeps lower-or-equal requests blocked.
- R12: `intAck` with no request forwarded returns the primary base with level 7 and changes no state.
- R13: A rising edge on a line in the same cycle that line is acknowledged leaves the line pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register bus write strobe |
| regSel | input | 2 | Bit 1 selects the unit, bit 0 selects command (0) or data (1) |
| regWrData | input | 8 | Register bus write byte |
| irqIn | input | 16 | Request inputs, lines 0-15 |
| intAck | input | 1 | One-cycle acknowledge pulse from the processor |
| intReq | output | 1 | Interrupt request to the processor |
| ackVector | output | 8 | Vector captured at the last acknowledge |

## Verification
A request edge can land in the same clock cycle as the acknowledge that takes that line out of the pending set. The bench sets up this collision by raising line 1 again on the exact cycle it pulses `intAck` for a pending line 1. It then expects the granted vector, a quiet output while level 1 is in service, and a fresh request as soon as the end-of-interrupt command for level 1 is written. A second run with the line held high confirms that no extra request appears without a new edge.

// File: rtl/picPkg.sv
package picPkg;
  localparam int LINE_CNT = 8;
  localparam int LVL_W    = $clog2(LINE_CNT);
  localparam int BYTE_W   = 8;

  typedef enum logic [1:0] {PH_RUN, PH_BASE, PH_CASC, PH_MODE} initPhaseT;

  typedef struct packed {
    logic              initClr;
    logic              baseLoad;
    logic              maskLoad;
    logic              eoiClr;
    logic [LVL_W-1:0]  eoiLvl;
    logic              ackTake;
    logic [LVL_W-1:0]  ackLvl;
    logic              inInit;
    logic [BYTE_W-1:0] wrData;
  } unitStrobeT;

  // Index of the lowest set bit (highest priority); 0 when none set.
  function automatic logic [LVL_W-1:0] lowestSet(input logic [LINE_CNT-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = LINE_CNT - 1; i >= 0; i--) begin
      if (v[i]) r = LVL_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/picUnit.sv
module picUnit
  import picPkg::*;
#(
  parameter bit                IS_MASTER = 1'b1,
  parameter int                CASC_LINE = 2,
  parameter logic [BYTE_W-1:0] RST_MASK  = 8'hFB,
  parameter logic [BYTE_W-1:0] RST_BASE  = 8'h00
) (
  input  logic                clk,
  input  logic                rstN,
  input  unitStrobeT          stb,
  input  logic [LINE_CNT-1:0] rawLines,
  input  logic                cascIn,
  output logic                intOut,
  output logic [LVL_W-1:0]    winLine,
  output logic [BYTE_W-1:0]   vecBase
);
  localparam logic [BYTE_W-1:0] BASE_KEEP = ~BYTE_W'((1 << LVL_W) - 1);

  logic [LINE_CNT-1:0] prevLines, irr, isr, mask;
  logic [LINE_CNT-1:0] edgeHit, edgeUse, reqView, eligible, ackSet, eoiClrV;
  logic [BYTE_W-1:0]   baseReg;
  logic [LVL_W-1:0]    isrTop;
  logic                blocked;

  assign edgeHit = rawLines & ~prevLines;

  generate
    if (IS_MASTER) begin : gCascadeHost
      // the cascade position is fed by the secondary unit, not by an input pin
      always_comb begin
        edgeUse            = edgeHit;
        edgeUse[CASC_LINE] = 1'b0;
      end
    end else begin : gLeaf
      assign edgeUse = edgeHit;
    end
  endgenerate

  always_comb begin
    reqView = irr;
    if (IS_MASTER) reqView[CASC_LINE] = cascIn;
  end

  assign eligible = reqView & ~mask;
  assign winLine  = lowestSet(eligible);
  assign isrTop   = lowestSet(isr);
  assign blocked  = (isr != '0) && (isrTop <= winLine);
  assign intOut   = (eligible != '0) && !blocked && !stb.inInit;
  assign ackSet   = stb.ackTake ? (LINE_CNT'(1) << stb.ackLvl) : '0;
  assign eoiClrV  = stb.eoiClr  ? (LINE_CNT'(1) << stb.eoiLvl) : '0;
  assign vecBase  = baseReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLines <= '0;
      irr       <= '0;
      isr       <= '0;
      mask      <= RST_MASK;
      baseReg   <= RST_BASE & BASE_KEEP;
    end else begin
      prevLines <= rawLines;
      if (stb.initClr) begin
        irr <= '0;
        isr <= '0;
      end else begin
        irr <= (irr & ~ackSet) | edgeUse;
        isr <= (isr & ~eoiClrV) | ackSet;
      end
      if (stb.maskLoad) mask    <= stb.wrData;
      if (stb.baseLoad) baseReg <= stb.wrData & BASE_KEEP;
    end
  end

  // R9: an accepted acknowledge leaves its level in service
  a_r9_ack_sets_isr: assert property (@(posedge clk) disable iff (!rstN)
    stb.ackTake && !stb.initClr |=> isr[$past(stb.ackLvl)]);

  // R5: an acknowledged line without a fresh edge is no longer pending
  a_r5_ack_drops_request: assert property (@(posedge clk) disable iff (!rstN)
    stb.ackTake && !stb.initClr && !edgeUse[stb.ackLvl] |=> !irr[$past(stb.ackLvl)]);

  // R10: a specific end-of-interrupt retires its level
  a_r10_eoi_clears_level: assert property (@(posedge clk) disable iff (!rstN)
    stb.eoiClr && !(stb.ackTake && stb.ackLvl == stb.eoiLvl) |=> !isr[$past(stb.eoiLvl)]);

  // R4: a forwarded request never sits on a masked line
  a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> !mask[winLine]);
endmodule

// File: rtl/picCtrl.sv
module picCtrl
  import picPkg::*;
#(
  parameter int CASC_LINE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              intAck,
  input  logic              mInt,
  input  logic [LVL_W-1:0]  mWin,
  input  logic [BYTE_W-1:0] mBase,
  input  logic              sInt,
  input  logic [LVL_W-1:0]  sWin,
  input  logic [BYTE_W-1:0] sBase,
  output unitStrobeT        mStb,
  output unitStrobeT        sStb,
  output logic [BYTE_W-1:0] ackVector
);
  localparam int         UNIT_CNT     = 2;
  localparam int         SEL_UNIT_BIT = 1;
  localparam int         SEL_PORT_BIT = 0;
  localparam int         INIT_BIT     = 4;
  localparam logic [2:0] EOI_CODE     = 3'b011;

  logic [UNIT_CNT-1:0] initStartV, eoiV, baseLoadV, maskLoadV, inInitV;
  logic                takeCasc;
  logic [BYTE_W-1:0]   vecNext;

  generate
    for (genvar c = 0; c < UNIT_CNT; c++) begin : gUnit
      initPhaseT phase;
      logic      hit, cmdWr, datWr;

      assign hit   = regWrEn && (regSel[SEL_UNIT_BIT] == 1'(c));
      assign cmdWr = hit && !regSel[SEL_PORT_BIT];
      assign datWr = hit &&  regSel[SEL_PORT_BIT];

      assign initStartV[c] = cmdWr && regWrData[INIT_BIT];
      assign eoiV[c]       = cmdWr && !regWrData[INIT_BIT] && (phase == PH_RUN)
                             && (regWrData[BYTE_W-1:BYTE_W-3] == EOI_CODE);
      assign baseLoadV[c]  = datWr && (phase == PH_BASE);
      assign maskLoadV[c]  = datWr && (phase == PH_RUN);
      assign inInitV[c]    = (phase != PH_RUN);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          phase <= PH_RUN;
        end else if (initStartV[c]) begin
          phase <= PH_BASE;
        end else if (datWr) begin
          unique case (phase)
            PH_BASE: phase <= PH_CASC;
            PH_CASC: phase <= PH_MODE;
            PH_MODE: phase <= PH_RUN;
            default: phase <= PH_RUN;
          endcase
        end
      end
    end
  endgenerate

  assign takeCasc = mInt && (mWin == LVL_W'(CASC_LINE));

  always_comb begin
    mStb.initClr  = initStartV[0];
    mStb.baseLoad = baseLoadV[0];
    mStb.maskLoad = maskLoadV[0];
    mStb.eoiClr   = eoiV[0];
    mStb.eoiLvl   = regWrData[LVL_W-1:0];
    mStb.ackTake  = intAck && mInt;
    mStb.ackLvl   = mWin;
    mStb.inInit   = inInitV[0];
    mStb.wrData   = regWrData;

    sStb.initClr  = initStartV[1];
    sStb.baseLoad = baseLoadV[1];
    sStb.maskLoad = maskLoadV[1];
    sStb.eoiClr   = eoiV[1];
    sStb.eoiLvl   = regWrData[LVL_W-1:0];
    sStb.ackTake  = intAck && takeCasc;
    sStb.ackLvl   = sWin;
    sStb.inInit   = inInitV[1];
    sStb.wrData   = regWrData;
  end

  always_comb begin
    if (!mInt)         vecNext = mBase | BYTE_W'(LINE_CNT - 1);
    else if (takeCasc) vecNext = sBase | BYTE_W'(sWin);
    else               vecNext = mBase | BYTE_W'(mWin);
  end

  always_ff @(posedge clk) begin
    if (!rstN)       ackVector <= '0;
    else if (intAck) ackVector <= vecNext;
  end

  // R2: a unit in its setup sequence forwards nothing
  a_r2_init_silences_primary: assert property (@(posedge clk) disable iff (!rstN)
    inInitV[0] |-> !mInt);

  // R12: acknowledge without a forwarded request yields level 7
  a_r12_spurious_level: assert property (@(posedge clk) disable iff (!rstN)
    intAck && !mInt |=> ackVector[LVL_W-1:0] == LVL_W'(LINE_CNT - 1));

  // R11: granting the cascade level implies the secondary holds a request
  a_r11_cascade_has_source: assert property (@(posedge clk) disable iff (!rstN)
    intAck && takeCasc |-> sInt);
endmodule

// File: rtl/picPair.sv
module picPair
  import picPkg::*;
#(
  parameter int                CASC_LINE     = 2,
  parameter logic [BYTE_W-1:0] PRI_RST_MASK  = 8'hFB,
  parameter logic [BYTE_W-1:0] SEC_RST_MASK  = 8'hFF,
  parameter logic [BYTE_W-1:0] PRI_RST_BASE  = 8'h00,
  parameter logic [BYTE_W-1:0] SEC_RST_BASE  = 8'h08
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic [1:0]              regSel,
  input  logic [BYTE_W-1:0]       regWrData,
  input  logic [2*LINE_CNT-1:0]   irqIn,
  input  logic                    intAck,
  output logic                    intReq,
  output logic [BYTE_W-1:0]       ackVector
);
  unitStrobeT        mStb, sStb;
  logic              mInt, sInt;
  logic [LVL_W-1:0]  mWin, sWin;
  logic [BYTE_W-1:0] mBase, sBase;

  picCtrl #(.CASC_LINE(CASC_LINE)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .intAck(intAck), .mInt(mInt), .mWin(mWin), .mBase(mBase),
    .sInt(sInt), .sWin(sWin), .sBase(sBase),
    .mStb(mStb), .sStb(sStb), .ackVector(ackVector)
  );

  picUnit #(.IS_MASTER(1'b1), .CASC_LINE(CASC_LINE), .RST_MASK(PRI_RST_MASK),
            .RST_BASE(PRI_RST_BASE)) u_primary (
    .clk(clk), .rstN(rstN), .stb(mStb), .rawLines(irqIn[LINE_CNT-1:0]), .cascIn(sInt),
    .intOut(mInt), .winLine(mWin), .vecBase(mBase)
  );

  picUnit #(.IS_MASTER(1'b0), .CASC_LINE(CASC_LINE), .RST_MASK(SEC_RST_MASK),
            .RST_BASE(SEC_RST_BASE)) u_secondary (
    .clk(clk), .rstN(rstN), .stb(sStb), .rawLines(irqIn[2*LINE_CNT-1:LINE_CNT]), .cascIn(1'b0),
    .intOut(sInt), .winLine(sWin), .vecBase(sBase)
  );

  assign intReq = mInt;
endmodule

// File: tb/picPair_tb.sv
module picPair_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [1:0] OP_WR = 2'd0, OP_RISE = 2'd1, OP_ACK = 2'd2;
  localparam logic [1:0] M_CMD = 2'b00, M_DAT = 2'b01, S_CMD = 2'b10, S_DAT = 2'b11;

  typedef logic [30:0] stepT; // op[30:29] arg[28:13] req[12] vec[11:4] rid[3:0]

  logic        clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0, intAck = 1'b0;
  logic [1:0]  regSel = '0;
  logic [7:0]  regWrData = '0;
  logic [15:0] irqIn = '0;
  logic        intReq;
  logic [7:0]  ackVector;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  picPair u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .irqIn(irqIn), .intAck(intAck), .intReq(intReq), .ackVector(ackVector)
  );

  function automatic stepT fnWr(input logic [1:0] sel, input logic [7:0] d, input logic er, input logic [3:0] rid);
    return {OP_WR, 6'd0, sel, d, er, 8'd0, rid};
  endfunction
  function automatic stepT fnRise(input logic [15:0] bits, input logic er, input logic [3:0] rid);
    return {OP_RISE, bits, er, 8'd0, rid};
  endfunction
  function automatic stepT fnAck(input logic [7:0] v, input logic er, input logic [3:0] rid);
    return {OP_ACK, 16'd0, er, v, rid};
  endfunction

  localparam int NSTEPS = 56;
  localparam stepT STEPS [NSTEPS] = '{
    // R2: setup of both units, bases 0x20 and 0x73 (low bits dropped -> 0x70)
    fnWr(M_CMD, 8'h11, 1'b0, 4'd2), fnWr(M_DAT, 8'h20, 1'b0, 4'd2),
    fnWr(M_DAT, 8'h04, 1'b0, 4'd2), fnWr(M_DAT, 8'h01, 1'b0, 4'd2),
    fnWr(S_CMD, 8'h11, 1'b0, 4'd2), fnWr(S_DAT, 8'h73, 1'b0, 4'd2),
    fnWr(S_DAT, 8'h02, 1'b0, 4'd2), fnWr(S_DAT, 8'h01, 1'b0, 4'd2),
    // R4: masked request held, forwarded after unmask
    fnRise(16'h0001, 1'b0, 4'd4), fnWr(M_DAT, 8'hF8, 1'b1, 4'd4),
    fnAck(8'h20, 1'b0, 4'd3),                                   // R3
    fnRise(16'h0002, 1'b0, 4'd8),                               // R8 blocked by level 0
    fnWr(M_CMD, 8'h60, 1'b1, 4'd10), fnAck(8'h21, 1'b0, 4'd3),  // R10, R3
    fnWr(M_CMD, 8'h61, 1'b0, 4'd10), fnWr(S_DAT, 8'h00, 1'b0, 4'd4),
    // R7 / R9 / R11: secondary lines 9 and 13
    fnRise(16'h2200, 1'b1, 4'd7), fnAck(8'h71, 1'b0, 4'd9),
    fnWr(S_CMD, 8'h61, 1'b0, 4'd11), fnWr(M_CMD, 8'h62, 1'b1, 4'd11),
    fnAck(8'h75, 1'b0, 4'd7), fnWr(S_CMD, 8'h65, 1'b0, 4'd11),
    fnWr(M_CMD, 8'h62, 1'b0, 4'd11),
    // R7: cascade (level 2) beats primary line 3
    fnWr(M_DAT, 8'hF0, 1'b0, 4'd4), fnRise(16'h0108, 1'b1, 4'd7),
    fnAck(8'h70, 1'b0, 4'd7), fnWr(S_CMD, 8'h60, 1'b0, 4'd11),
    fnWr(M_CMD, 8'h62, 1'b1, 4'd11), fnAck(8'h23, 1'b0, 4'd3),
    fnWr(M_CMD, 8'h63, 1'b0, 4'd10),
    // R7: primary line 0 beats secondary line 15
    fnRise(16'h8001, 1'b1, 4'd7), fnAck(8'h20, 1'b0, 4'd7),
    fnWr(M_CMD, 8'h60, 1'b1, 4'd10), fnAck(8'h77, 1'b0, 4'd3),
    fnWr(S_CMD, 8'h67, 1'b0, 4'd11), fnWr(M_CMD, 8'h62, 1'b0, 4'd11),
    fnRise(16'h0004, 1'b0, 4'd6),                               // R6
    fnAck(8'h27, 1'b0, 4'd12),                                  // R12
    // R8 / R10: nesting and level-specific retirement
    fnRise(16'h0002, 1'b1, 4'd8), fnAck(8'h21, 1'b0, 4'd9),
    fnRise(16'h0001, 1'b1, 4'd8), fnAck(8'h20, 1'b0, 4'd8),
    fnWr(M_CMD, 8'h61, 1'b0, 4'd10), fnRise(16'h0008, 1'b0, 4'd8),
    fnWr(M_CMD, 8'h20, 1'b0, 4'd10),                            // R10 other command ignored
    fnWr(M_CMD, 8'h60, 1'b1, 4'd10), fnAck(8'h23, 1'b0, 4'd3),
    fnWr(M_CMD, 8'h63, 1'b0, 4'd10),
    // R2: re-setup clears pending, holds output, keeps mask
    fnRise(16'h0001, 1'b1, 4'd2), fnWr(M_CMD, 8'h11, 1'b0, 4'd2),
    fnWr(M_DAT, 8'h20, 1'b0, 4'd2), fnRise(16'h0001, 1'b0, 4'd2),
    fnWr(M_DAT, 8'h04, 1'b0, 4'd2), fnWr(M_DAT, 8'h01, 1'b1, 4'd2),
    fnAck(8'h20, 1'b0, 4'd3), fnWr(M_CMD, 8'h60, 1'b0, 4'd10)
  };

  task automatic checkVal(input string what, input int rid, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", rid, what, act, exp);
    end
  endtask

  task automatic runStep(input stepT s);
    logic [1:0]  op;
    logic [15:0] arg;
    op  = s[30:29];
    arg = s[28:13];
    @(negedge clk);
    case (op)
      OP_WR:   begin regWrEn = 1'b1; regSel = arg[9:8]; regWrData = arg[7:0]; end
      OP_RISE: irqIn = irqIn | arg;
      default: intAck = 1'b1;
    endcase
    @(negedge clk);
    if (op == OP_ACK) checkVal("ackVector", int'(s[3:0]), ackVector, s[11:4]);
    checkVal("intReq", int'(s[3:0]), {7'd0, intReq}, {7'd0, s[12]});
    regWrEn = 1'b0;
    intAck  = 1'b0;
    if (op == OP_RISE) irqIn = irqIn & ~arg;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVal("intReq in reset", 1, {7'd0, intReq}, 8'd0);        // R1
    checkVal("ackVector in reset", 1, ackVector, 8'h00);          // R1
    rstN = 1'b1;
    runStep(fnRise(16'h0001, 1'b0, 4'd1));   // R1 primary line 0 masked (0xFB)
    runStep(fnRise(16'h0100, 1'b0, 4'd1));   // R1 secondary masked (0xFF)
    runStep(fnAck(8'h07, 1'b0, 4'd1));       // R1 primary base 0x00, level 7
    runStep(fnWr(S_DAT, 8'h00, 1'b1, 4'd1)); // R1 cascade line open at reset
    runStep(fnAck(8'h08, 1'b0, 4'd1));       // R1 secondary base 0x08
    runStep(fnWr(S_CMD, 8'h60, 1'b0, 4'd11));
    runStep(fnWr(M_CMD, 8'h62, 1'b0, 4'd11));

    for (int i = 0; i < NSTEPS; i++) runStep(STEPS[i]);

    // R5: single edge makes line 1 pending
    @(negedge clk); irqIn[1] = 1'b1;
    @(negedge clk); irqIn[1] = 1'b0;
    checkVal("intReq after edge", 5, {7'd0, intReq}, 8'd1);
    // R13: new edge in the acknowledge cycle of the same line
    @(negedge clk); intAck = 1'b1; irqIn[1] = 1'b1;
    @(negedge clk); intAck = 1'b0;
    checkVal("ackVector collide", 13, ackVector, 8'h21);
    checkVal("intReq collide", 13, {7'd0, intReq}, 8'd0);
    runStep(fnWr(M_CMD, 8'h61, 1'b1, 4'd13));
    runStep(fnAck(8'h21, 1'b0, 4'd13));
    // R5: held level gives no new request
    runStep(fnWr(M_CMD, 8'h61, 1'b0, 4'd5));
    @(negedge clk); irqIn[1] = 1'b0;
    @(negedge clk); irqIn[1] = 1'b1;
    @(negedge clk);
    checkVal("intReq after re-edge", 5, {7'd0, intReq}, 8'd1);
    irqIn[1] = 1'b0;
    runStep(fnAck(8'h21, 1'b0, 4'd9));
    runStep(fnWr(M_CMD, 8'h61, 1'b0, 4'd10));

    finishRun();
  end
endmodule